// File: doc/BRIEF.md
# IDE Chip-Select and Data-Buffer Enable Decoder

This block sits on an ISA-style I/O bus and turns each address into the two active-low chip selects of an IDE drive, plus the active-low enables for the low-byte and high-byte data transceivers. Two strap pins are captured while reset is held. One strap picks the register window: the primary window is a task file at 1F0h–1F7h with control registers at 3F6h–3F7h. The secondary window is a task file at 170h–177h with control registers at 376h–377h. The other strap switches the whole IDE function on or off.

The decode is combinational from the address, AEN, the read/write strobes and the drive's 16-bit transfer indication. It is gated by a small mode machine. The machine has four states. ST_SAMPLE is entered whenever reset is high and is held for one clock after reset releases. ST_PRIMARY and ST_SECONDARY are the two live decode states. ST_OFF is the disabled state. The only transitions leave ST_SAMPLE: it moves to ST_OFF if the captured disable strap is high, otherwise to ST_PRIMARY if the captured window strap is high, otherwise to ST_SECONDARY. The three settled states hold until the next reset, and reset returns the machine to ST_SAMPLE from any state.

Top module: `ide_select_decoder`

## Requirements
- R1: In the primary window, `cs0_n` is low exactly for addresses 1F0h–1F7h. Neighbours such as 1EFh and 1F8h leave it high.
- R2: In the primary window, `cs1_n` is low exactly for addresses 3F6h and 3F7h. 3F5h leaves it high.
- R3: With `strap_win_pri` low at capture, `cs0_n` decodes 170h–177h and `cs1_n` decodes 376h–377h. The primary addresses then decode nothing, and in the primary window the secondary addresses decode nothing.
- R4: With `strap_ide_off` high at capture, all four outputs stay high for every address and strobe.
- R5: The straps are captured on each clock edge while `rst` is high, so the value at the last edge before release is kept. Strap changes after release have no effect until the next reset. In the first cycle after release all outputs are high.
- R6: While `aen` is high, all four outputs are high.
- R7: While `rst` is high, all four outputs are high.
- R8: `dben_lo_n` is low only when `ior_n` or `iow_n` is low and the address is in the selected task-file range or control range.
- R9: `dben_hi_n` is low only when a strobe is active, the address is in the selected task-file range and `io16_n` is low. It is never low for the control range.
- R10: The chip selects follow the address decode whether or not a strobe is active.
- R11: `cs0_n` and `cs1_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode machine |
| rst | input | 1 | Synchronous reset, active high; straps are captured while high |
| strap_win_pri | input | 1 | Window strap: 1 selects the primary window, 0 the secondary |
| strap_ide_off | input | 1 | Disable strap: 1 disables all outputs |
| addr | input | 10 | I/O address bus |
| aen | input | 1 | Address enable; high marks a DMA cycle, so no I/O decode happens |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| io16_n | input | 1 | 16-bit transfer indication from the drive, active low |
| cs0_n | output | 1 | Task-file chip select, active low |
| cs1_n | output | 1 | Control-register chip select, active low |
| dben_lo_n | output | 1 | Low-byte data buffer enable, active low |
| dben_hi_n | output | 1 | High-byte data buffer enable, active low |

## Verification
A wrong mode state shows up as soon as the first access after reset release is decoded. A state stuck in ST_SAMPLE or ST_OFF leaves every output high. A swapped window decodes the other window's addresses in that same cycle. A strap that is captured at the wrong time shows the stale window on the first live access. Because the decode is combinational, a gating error in the enables is visible on the very access that exposes it; no extra clock is needed.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

    // Mode of the decoder as settled from the straps
    typedef enum logic [1:0] {
        ST_SAMPLE    = 2'd0,
        ST_PRIMARY   = 2'd1,
        ST_SECONDARY = 2'd2,
        ST_OFF       = 2'd3
    } ide_mode_e;

    // Active-low output bundle
    typedef struct packed {
        logic cs0_n;
        logic cs1_n;
        logic dben_lo_n;
        logic dben_hi_n;
    } ide_sel_t;

    localparam ide_sel_t SEL_IDLE = '{cs0_n: 1'b1, cs1_n: 1'b1, dben_lo_n: 1'b1, dben_hi_n: 1'b1};

endpackage

// File: rtl/ide_window_match.sv
module ide_window_match #(
    parameter int              ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE    = '0,
    parameter int              SPAN_LOG2 = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TAG_LO = SPAN_LOG2;

    // An aligned window of 2**SPAN_LOG2 addresses: compare the upper tag only
    assign hit = (addr[ADDR_W-1:TAG_LO] == BASE[ADDR_W-1:TAG_LO]);
endmodule

// File: rtl/ide_strap_fsm.sv
module ide_strap_fsm
    import ide_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strap_win_pri,
    input  logic      strap_ide_off,
    output ide_mode_e mode
);
    logic      win_pri_q;
    logic      ide_off_q;
    ide_mode_e state_q;
    ide_mode_e state_d;

    // Strap capture: follows the pins only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            win_pri_q <= strap_win_pri;
            ide_off_q <= strap_ide_off;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: begin
                if (ide_off_q) begin
                    state_d = ST_OFF;
                end else if (win_pri_q) begin
                    state_d = ST_PRIMARY;
                end else begin
                    state_d = ST_SECONDARY;
                end
            end
            ST_PRIMARY:   state_d = ST_PRIMARY;
            ST_SECONDARY: state_d = ST_SECONDARY;
            ST_OFF:       state_d = ST_OFF;
            default:      state_d = ST_SAMPLE;
        endcase
    end

    assign mode = state_q;
endmodule

// File: rtl/ide_select_logic.sv
module ide_select_logic
    import ide_dec_pkg::*;
(
    input  ide_mode_e mode,
    input  logic      rst,
    input  logic      aen,
    input  logic      ior_n,
    input  logic      iow_n,
    input  logic      io16_n,
    input  logic      task_hit_pri,
    input  logic      task_hit_sec,
    input  logic      ctl_hit_pri,
    input  logic      ctl_hit_sec,
    output ide_sel_t  sel
);
    logic strobe;
    logic task_hit;
    logic ctl_hit;
    logic live;

    assign strobe = ~ior_n | ~iow_n;

    // Output process: window choice and gating per mode
    always_comb begin
        live     = 1'b0;
        task_hit = 1'b0;
        ctl_hit  = 1'b0;
        unique case (mode)
            ST_PRIMARY: begin
                live     = 1'b1;
                task_hit = task_hit_pri;
                ctl_hit  = ctl_hit_pri;
            end
            ST_SECONDARY: begin
                live     = 1'b1;
                task_hit = task_hit_sec;
                ctl_hit  = ctl_hit_sec;
            end
            ST_SAMPLE, ST_OFF: begin
                live = 1'b0;
            end
            default: live = 1'b0;
        endcase

        sel = SEL_IDLE;
        if (live && !rst && !aen) begin
            sel.cs0_n     = ~task_hit;
            sel.cs1_n     = ~ctl_hit;
            sel.dben_lo_n = ~(strobe & (task_hit | ctl_hit));
            sel.dben_hi_n = ~(strobe & task_hit & ~io16_n);
        end
    end
endmodule

// File: rtl/ide_select_decoder.sv
module ide_select_decoder
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W         = 10,
    parameter int PRI_TASK_BASE  = 'h1F0,
    parameter int SEC_TASK_BASE  = 'h170,
    parameter int PRI_CTL_BASE   = 'h3F6,
    parameter int SEC_CTL_BASE   = 'h376,
    parameter int TASK_SPAN_LOG2 = 3,
    parameter int CTL_SPAN_LOG2  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_win_pri,
    input  logic              strap_ide_off,
    input  logic [ADDR_W-1:0] addr,
    input  logic              aen,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic              io16_n,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic              dben_lo_n,
    output logic              dben_hi_n
);
    localparam int NUM_WIN = 2;

    ide_mode_e          cur_mode;
    ide_sel_t           sel;
    logic [NUM_WIN-1:0] task_hit;
    logic [NUM_WIN-1:0] ctl_hit;

    ide_strap_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .strap_win_pri (strap_win_pri),
        .strap_ide_off (strap_ide_off),
        .mode          (cur_mode)
    );

    // Index 0 is the primary window, index 1 the secondary
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [ADDR_W-1:0] TBASE = ADDR_W'((g == 0) ? PRI_TASK_BASE : SEC_TASK_BASE);
        localparam logic [ADDR_W-1:0] CBASE = ADDR_W'((g == 0) ? PRI_CTL_BASE  : SEC_CTL_BASE);

        ide_window_match #(
            .ADDR_W    (ADDR_W),
            .BASE      (TBASE),
            .SPAN_LOG2 (TASK_SPAN_LOG2)
        ) u_task (
            .addr (addr),
            .hit  (task_hit[g])
        );

        ide_window_match #(
            .ADDR_W    (ADDR_W),
            .BASE      (CBASE),
            .SPAN_LOG2 (CTL_SPAN_LOG2)
        ) u_ctl (
            .addr (addr),
            .hit  (ctl_hit[g])
        );
    end

    ide_select_logic u_sel (
        .mode         (cur_mode),
        .rst          (rst),
        .aen          (aen),
        .ior_n        (ior_n),
        .iow_n        (iow_n),
        .io16_n       (io16_n),
        .task_hit_pri (task_hit[0]),
        .task_hit_sec (task_hit[1]),
        .ctl_hit_pri  (ctl_hit[0]),
        .ctl_hit_sec  (ctl_hit[1]),
        .sel          (sel)
    );

    assign cs0_n     = sel.cs0_n;
    assign cs1_n     = sel.cs1_n;
    assign dben_lo_n = sel.dben_lo_n;
    assign dben_hi_n = sel.dben_hi_n;
endmodule

// File: rtl/ide_select_decoder_chk.sv
module ide_select_decoder_chk
    import ide_dec_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      aen,
    input logic      ior_n,
    input logic      iow_n,
    input logic      io16_n,
    input ide_mode_e cur_mode,
    input logic      cs0_n,
    input logic      cs1_n,
    input logic      dben_lo_n,
    input logic      dben_hi_n
);
    logic all_idle;
    assign all_idle = cs0_n & cs1_n & dben_lo_n & dben_hi_n;

    assert_aen_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        aen |-> all_idle);

    assert_cs_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~cs0_n, ~cs1_n}));

    assert_hi_needs_io16_R9: assert property (@(posedge clk) disable iff (rst)
        !dben_hi_n |-> (!io16_n && !cs0_n && !dben_lo_n));

    assert_buf_needs_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !dben_lo_n |-> (!ior_n || !iow_n));

    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == ST_OFF) |-> all_idle);

    assert_settle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == ST_SAMPLE) |-> all_idle);

    assert_mode_held_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(cur_mode) != ST_SAMPLE) |-> $stable(cur_mode));
endmodule

bind ide_select_decoder ide_select_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .aen       (aen),
    .ior_n     (ior_n),
    .iow_n     (iow_n),
    .io16_n    (io16_n),
    .cur_mode  (cur_mode),
    .cs0_n     (cs0_n),
    .cs1_n     (cs1_n),
    .dben_lo_n (dben_lo_n),
    .dben_hi_n (dben_hi_n)
);

// File: tb/ide_select_decoder_bench.sv
module ide_select_decoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_win_pri = 1'b1;
    logic       strap_ide_off = 1'b0;
    logic [9:0] addr = '0;
    logic       aen = 1'b0;
    logic       ior_n = 1'b1;
    logic       iow_n = 1'b1;
    logic       io16_n = 1'b1;
    logic       cs0_n, cs1_n, dben_lo_n, dben_hi_n;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;
    int bmode = 0; // bench's view: 0 settle, 1 primary, 2 secondary, 3 off

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t scb[$];
    event  pushed;

    always #5 clk = ~clk;

    ide_select_decoder u_ide_select_decoder (
        .clk           (clk),
        .rst           (rst),
        .strap_win_pri (strap_win_pri),
        .strap_ide_off (strap_ide_off),
        .addr          (addr),
        .aen           (aen),
        .ior_n         (ior_n),
        .iow_n         (iow_n),
        .io16_n        (io16_n),
        .cs0_n         (cs0_n),
        .cs1_n         (cs1_n),
        .dben_lo_n     (dben_lo_n),
        .dben_hi_n     (dben_hi_n)
    );

    // Expected outputs {cs0_n, cs1_n, dben_lo_n, dben_hi_n} from the requirements
    function automatic logic [3:0] model(int m, logic r, logic [9:0] a, logic ae,
                                         logic rd_n, logic wr_n, logic w16_n);
        logic [9:0] tb;
        logic [9:0] cb;
        logic t, c, s;
        if (r || ae || m == 0 || m == 3) return 4'hF;
        tb = (m == 1) ? 10'h1F0 : 10'h170;
        cb = (m == 1) ? 10'h3F6 : 10'h376;
        t  = (a[9:3] == tb[9:3]);
        c  = (a[9:1] == cb[9:1]);
        s  = !rd_n || !wr_n;
        return {!t, !c, !(s && (t || c)), !(s && t && !w16_n)};
    endfunction

    task automatic push_check(string tag);
        item_t it;
        it.exp = model(bmode, rst, addr, aen, ior_n, iow_n, io16_n);
        it.tag = tag;
        scb.push_back(it);
        ->pushed;
    endtask

    task automatic drive(logic [9:0] a, logic ae, logic rd_n, logic wr_n, logic w16_n, string tag);
        @(negedge clk);
        addr = a; aen = ae; ior_n = rd_n; iow_n = wr_n; io16_n = w16_n;
        push_check(tag);
    endtask

    // Monitor: compare each expected item against the ports just after it is queued
    initial begin
        forever begin
            item_t it;
            logic [3:0] act;
            @(pushed);
            #1;
            it  = scb.pop_front();
            act = {cs0_n, cs1_n, dben_lo_n, dben_hi_n};
            compared++;
            if (act !== it.exp) begin
                mismatched++;
                $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    task automatic do_reset(logic win_pri, logic ide_off, int next_mode);
        @(negedge clk);
        rst = 1'b1; bmode = 0;
        strap_win_pri = win_pri; strap_ide_off = ide_off;
        repeat (2) @(negedge clk);
        addr = 10'h1F0; ior_n = 1'b0; iow_n = 1'b1; aen = 1'b0; io16_n = 1'b0;
        push_check("R7 outputs idle in reset");
        @(negedge clk);
        rst = 1'b0;
        // Flip the pins right at release; the captured values must win
        strap_win_pri = ~win_pri; strap_ide_off = ~ide_off;
        push_check("R5 settle cycle idle");
        bmode = next_mode;
    endtask

    initial begin
        do_reset(1'b1, 1'b0, 1);
        // Primary window
        drive(10'h1F0, 0, 1, 1, 1, "R1 R10 task start no strobe");
        drive(10'h1F7, 0, 0, 1, 0, "R1 R8 R9 task end read 16-bit");
        drive(10'h1F8, 0, 0, 1, 0, "R1 above task range");
        drive(10'h1EF, 0, 0, 1, 0, "R1 below task range");
        drive(10'h3F6, 0, 1, 0, 0, "R2 R9 ctl write no high byte");
        drive(10'h3F7, 0, 1, 1, 0, "R2 R10 ctl no strobe");
        drive(10'h3F5, 0, 0, 1, 0, "R2 below ctl range");
        drive(10'h1F3, 0, 0, 1, 1, "R9 8-bit read no high byte");
        drive(10'h1F3, 0, 1, 0, 0, "R8 R9 write 16-bit");
        drive(10'h1F3, 1, 0, 1, 0, "R6 aen blocks decode");
        drive(10'h3F6, 1, 1, 1, 1, "R6 aen blocks ctl");
        drive(10'h170, 0, 0, 1, 0, "R3 secondary addr ignored in primary");
        drive(10'h376, 0, 0, 1, 0, "R3 secondary ctl ignored in primary");
        drive(10'h1F4, 0, 1, 1, 0, "R11 R10 io16 without strobe");
        // Secondary window
        do_reset(1'b0, 1'b0, 2);
        drive(10'h170, 0, 0, 1, 0, "R3 secondary task start");
        drive(10'h177, 0, 1, 0, 1, "R3 R8 secondary task end 8-bit");
        drive(10'h178, 0, 0, 1, 0, "R3 above secondary task");
        drive(10'h376, 0, 0, 1, 0, "R3 R9 secondary ctl");
        drive(10'h377, 0, 1, 1, 0, "R3 secondary ctl no strobe");
        drive(10'h1F0, 0, 0, 1, 0, "R3 primary task ignored");
        drive(10'h3F6, 0, 0, 1, 0, "R3 primary ctl ignored");
        // Disabled
        do_reset(1'b1, 1'b1, 3);
        drive(10'h1F0, 0, 0, 1, 0, "R4 disabled task");
        drive(10'h3F7, 0, 1, 0, 0, "R4 disabled ctl");
        drive(10'h170, 0, 0, 1, 0, "R4 disabled secondary");
        // Back to primary: a new reset recaptures
        do_reset(1'b1, 1'b0, 1);
        drive(10'h1F2, 0, 0, 1, 0, "R5 recapture primary");
        repeat (5) drive(10'h3F7, 0, 0, 1, 0, "R5 mode held after release");
        @(negedge clk);
        #2;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule